// File: doc/BRIEF.md
# Quad Thread Dispatch Scheduler

The block keeps a pool of pixel-quad threads. Each pool entry holds a lifecycle state, a shader program counter, a launch-time condition bit and a predicate flag. Every cycle the scheduler looks up the next instruction of every ready quad in a small program image. Ready quads whose instruction needs the arithmetic units go to the ALU lanes. Ready quads whose instruction needs a texture fetch go to the texture lanes. Issue follows whichever lanes are free in that cycle, not a fixed rotation through the pool.

A quad that sends a texture fetch is parked until its result comes back. While it is parked, other quads keep using both kinds of lane. Predicate-setting instructions and instructions that a quad's predicate masks off take no lane: the quad simply steps past them in one cycle. Within each lane class, a rotating priority pointer orders the ready quads so that none is starved. A quad that reaches an end instruction retires, and its entry returns to the free pool.

Top module: `quad_dispatch`

## Requirements
- R1: After reset every entry is free. No lane is valid, `retire_mask` is zero, `alloc_ready` is 1 and `alloc_id` is 0.
- R2: `alloc_ready` is 1 exactly when some entry is free, and `alloc_id` is then the lowest-numbered free entry. When `alloc_valid` and `alloc_ready` are both high at a clock edge, that entry becomes ready with PC = `alloc_pc`, condition bit = `alloc_cond` and predicate = 1.
- R3: Program word k sits at bits [3k+2:3k] of `prog_image`. Bits [1:0] give the class: 0 = ALU, 1 = TEX, 2 = predicate-set, 3 = end. Bit 2 is the predicate-select bit.
- R4: A ready quad whose instruction is an ALU instruction that runs is eligible for the ALU lanes. Each cycle at most one quad per enabled lane is issued. An issued quad's PC advances by 1. The `alu_pc` lane output shows the PC of the issued instruction.
- R5: A TEX instruction that runs issues through the texture lanes under the same lane rule. The issued quad is parked with its PC unchanged, and no parked quad ever appears on any lane.
- R6: A texture return whose `tex_ret_id` names a parked quad makes that quad ready and advances its PC by 1 on the same edge. A return that names any other quad changes nothing.
- R7: An ALU or TEX instruction with select bit 1 does not run when the quad's predicate is 0. The quad then advances its PC by 1 in one cycle and appears on no lane.
- R8: A predicate-set instruction loads predicate = condition bit XOR select bit and advances the PC by 1, using no lane.
- R9: An end instruction moves a ready quad to the done state. Its bit in `retire_mask` is high for exactly one cycle, and the entry is free on the following cycle.
- R10: In each class, the search for eligible quads starts at that class's pointer and wraps around the pool. After a cycle with at least one grant, the pointer moves to one past the last granted quad. After a cycle with no grant, it stays where it is.
- R11: The r-th chosen quad (counting from 0 in search order) goes to the r-th enabled lane, counting lanes from index 0. A disabled lane is never valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to launch a quad |
| alloc_pc | input | PCW | Start PC of the launched quad |
| alloc_cond | input | 1 | Condition bit of the launched quad |
| alloc_ready | output | 1 | A free entry exists |
| alloc_id | output | log2(NQ) | Entry the launch will take |
| prog_image | input | 3*2^PCW | Program words, 3 bits each |
| alu_lane_en | input | LANES | ALU lanes free this cycle |
| tex_lane_en | input | LANES | Texture lanes free this cycle |
| alu_valid | output | LANES | ALU lane carries an issued quad |
| alu_id | output | LANES*log2(NQ) | Quad index per ALU lane |
| alu_pc | output | LANES*PCW | Issued PC per ALU lane |
| tex_valid | output | LANES | Texture lane carries an issued quad |
| tex_id | output | LANES*log2(NQ) | Quad index per texture lane |
| tex_pc | output | LANES*PCW | Issued PC per texture lane |
| tex_ret_valid | input | 1 | A texture result returns |
| tex_ret_id | input | log2(NQ) | Quad the result belongs to |
| retire_mask | output | NQ | Quads in the done state this cycle |

## Verification
The hardest situation to reach is a full pool in which parked quads, ready quads and quads just retiring all coexist while lanes are withheld. In that state the rotating pointers, lowest-free allocation and the refusal to issue parked quads all act at once. The stimulus gets there by launching quads faster than they can finish, holding texture results for several cycles, and masking lanes with a pseudo-random pattern once the first burst is over. Stray texture returns aimed at quads that are not parked check that such returns are ignored.

// File: rtl/qd_pkg.sv
package qd_pkg;

    localparam int INSTR_W = 3;

    typedef enum logic [1:0] {
        Q_FREE  = 2'd0,
        Q_READY = 2'd1,
        Q_WAIT  = 2'd2,
        Q_DONE  = 2'd3
    } qstate_e;

    typedef enum logic [1:0] {
        OP_ALU  = 2'd0,
        OP_TEX  = 2'd1,
        OP_PSET = 2'd2,
        OP_END  = 2'd3
    } opcls_e;

    typedef struct packed {
        logic   psel;
        opcls_e cls;
    } instr_t;

    // An instruction runs unless it is predicate-selected and the flag is clear.
    function automatic logic runs(instr_t ins, logic pred);
        return !(ins.psel && !pred);
    endfunction

endpackage

// File: rtl/qd_first_free.sv
module qd_first_free #(
    parameter int N = 64
) (
    input  logic [N-1:0]         vec,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int W = $clog2(N);

    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/qd_rr_pick.sv
module qd_rr_pick #(
    parameter int N     = 64,
    parameter int LANES = 4
) (
    input  logic [N-1:0]               elig,
    input  logic [$clog2(N)-1:0]       ptr,
    input  logic [LANES-1:0]           lane_en,
    output logic [N-1:0]               grant,
    output logic [LANES-1:0]           lane_valid,
    output logic [LANES*$clog2(N)-1:0] lane_id,
    output logic [$clog2(N)-1:0]       ptr_next
);
    localparam int W = $clog2(N);

    logic [2*N-1:0]   dbl_el, dbl_gr;
    logic [N-1:0]     rot_el, rot_gr;
    logic [W-1:0]     pick_id [LANES];
    logic [LANES-1:0] pick_v;

    function automatic logic [W-1:0] wrap_add(logic [W-1:0] a, int b);
        int s;
        s = int'(a) + b;
        if (s >= N) s = s - N;
        return W'(s);
    endfunction

    always_comb begin
        int navail;
        int cnt;
        int last;
        int rank;
        dbl_el = {elig, elig} >> ptr;
        rot_el = dbl_el[N-1:0];
        navail = 0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_en[l]) navail++;
        end
        cnt    = 0;
        last   = -1;
        rot_gr = '0;
        pick_v = '0;
        for (int r = 0; r < LANES; r++) pick_id[r] = '0;
        for (int i = 0; i < N; i++) begin
            if (rot_el[i] && cnt < navail) begin
                rot_gr[i] = 1'b1;
                for (int r = 0; r < LANES; r++) begin
                    if (r == cnt) begin
                        pick_id[r] = wrap_add(ptr, i);
                        pick_v[r]  = 1'b1;
                    end
                end
                cnt++;
                last = i;
            end
        end
        dbl_gr   = {rot_gr, rot_gr} << ptr;
        grant    = dbl_gr[2*N-1:N];
        ptr_next = (last >= 0) ? wrap_add(ptr, last + 1) : ptr;
        rank       = 0;
        lane_valid = '0;
        lane_id    = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_en[l]) begin
                for (int r = 0; r < LANES; r++) begin
                    if (r == rank) begin
                        lane_valid[l]      = pick_v[r];
                        lane_id[l*W +: W]  = pick_id[r];
                    end
                end
                rank++;
            end
        end
    end
endmodule

// File: rtl/quad_dispatch.sv
module quad_dispatch
    import qd_pkg::*;
#(
    parameter int NQ    = 64,
    parameter int LANES = 4,
    parameter int PCW   = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          alloc_valid,
    input  logic [PCW-1:0]                alloc_pc,
    input  logic                          alloc_cond,
    output logic                          alloc_ready,
    output logic [$clog2(NQ)-1:0]         alloc_id,
    input  logic [INSTR_W*(1<<PCW)-1:0]   prog_image,
    input  logic [LANES-1:0]              alu_lane_en,
    input  logic [LANES-1:0]              tex_lane_en,
    output logic [LANES-1:0]              alu_valid,
    output logic [LANES*$clog2(NQ)-1:0]   alu_id,
    output logic [LANES*PCW-1:0]          alu_pc,
    output logic [LANES-1:0]              tex_valid,
    output logic [LANES*$clog2(NQ)-1:0]   tex_id,
    output logic [LANES*PCW-1:0]          tex_pc,
    input  logic                          tex_ret_valid,
    input  logic [$clog2(NQ)-1:0]         tex_ret_id,
    output logic [NQ-1:0]                 retire_mask
);
    localparam int QW = $clog2(NQ);

    qstate_e        st_q  [NQ];
    logic [PCW-1:0] pc_q  [NQ];
    logic [NQ-1:0]  pred_q, cond_q;
    instr_t         cur   [NQ];
    logic [NQ-1:0]  alu_el, tex_el, free_v, wait_v;
    logic [NQ-1:0]  alu_gr, tex_gr;
    logic [QW-1:0]  alu_ptr, tex_ptr, alu_ptr_n, tex_ptr_n;
    logic           alloc_take;

    // Instruction lookup and per-quad eligibility
    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            cur[i]         = instr_t'(prog_image[int'(pc_q[i])*INSTR_W +: INSTR_W]);
            alu_el[i]      = (st_q[i] == Q_READY) && (cur[i].cls == OP_ALU) && runs(cur[i], pred_q[i]);
            tex_el[i]      = (st_q[i] == Q_READY) && (cur[i].cls == OP_TEX) && runs(cur[i], pred_q[i]);
            free_v[i]      = (st_q[i] == Q_FREE);
            wait_v[i]      = (st_q[i] == Q_WAIT);
            retire_mask[i] = (st_q[i] == Q_DONE);
        end
    end

    qd_first_free #(.N(NQ)) u_free (
        .vec(free_v), .found(alloc_ready), .idx(alloc_id)
    );

    qd_rr_pick #(.N(NQ), .LANES(LANES)) u_alu_pick (
        .elig(alu_el), .ptr(alu_ptr), .lane_en(alu_lane_en), .grant(alu_gr),
        .lane_valid(alu_valid), .lane_id(alu_id), .ptr_next(alu_ptr_n)
    );

    qd_rr_pick #(.N(NQ), .LANES(LANES)) u_tex_pick (
        .elig(tex_el), .ptr(tex_ptr), .lane_en(tex_lane_en), .grant(tex_gr),
        .lane_valid(tex_valid), .lane_id(tex_id), .ptr_next(tex_ptr_n)
    );

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            alu_pc[l*PCW +: PCW] = pc_q[alu_id[l*QW +: QW]];
            tex_pc[l*PCW +: PCW] = pc_q[tex_id[l*QW +: QW]];
        end
    end

    assign alloc_take = alloc_valid && alloc_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            alu_ptr <= '0;
            tex_ptr <= '0;
            pred_q  <= '0;
            cond_q  <= '0;
            for (int i = 0; i < NQ; i++) begin
                st_q[i] <= Q_FREE;
                pc_q[i] <= '0;
            end
        end else begin
            alu_ptr <= alu_ptr_n;
            tex_ptr <= tex_ptr_n;
            for (int i = 0; i < NQ; i++) begin
                unique case (st_q[i])
                    Q_FREE: if (alloc_take && alloc_id == QW'(i)) begin
                        st_q[i]   <= Q_READY;
                        pc_q[i]   <= alloc_pc;
                        pred_q[i] <= 1'b1;
                        cond_q[i] <= alloc_cond;
                    end
                    Q_DONE: st_q[i] <= Q_FREE;
                    Q_WAIT: if (tex_ret_valid && tex_ret_id == QW'(i)) begin
                        st_q[i] <= Q_READY;
                        pc_q[i] <= pc_q[i] + 1'b1;
                    end
                    Q_READY: unique case (cur[i].cls)
                        OP_END:  st_q[i] <= Q_DONE;
                        OP_PSET: begin
                            pred_q[i] <= cond_q[i] ^ cur[i].psel;
                            pc_q[i]   <= pc_q[i] + 1'b1;
                        end
                        OP_ALU: if (!runs(cur[i], pred_q[i]) || alu_gr[i])
                            pc_q[i] <= pc_q[i] + 1'b1;
                        OP_TEX: begin
                            if (!runs(cur[i], pred_q[i])) pc_q[i] <= pc_q[i] + 1'b1;
                            else if (tex_gr[i])           st_q[i] <= Q_WAIT;
                        end
                    endcase
                endcase
            end
        end
    end

    // Launch lands in the chosen entry as a ready quad
    assert_alloc_lands_R2: assert property (@(posedge clk) disable iff (rst)
        alloc_take |=> st_q[$past(alloc_id)] == Q_READY);

    // Parked quads never reach a lane
    assert_no_parked_issue_R5: assert property (@(posedge clk) disable iff (rst)
        ((alu_gr | tex_gr) & wait_v) == '0);

    // One quad never takes both an ALU and a texture slot
    assert_class_disjoint_R4: assert property (@(posedge clk) disable iff (rst)
        (alu_gr & tex_gr) == '0);

    // Matching texture return unparks the quad
    assert_return_wakes_R6: assert property (@(posedge clk) disable iff (rst)
        (tex_ret_valid && wait_v[tex_ret_id]) |=> st_q[$past(tex_ret_id)] == Q_READY);

    // Withheld lanes stay idle
    assert_lane_mask_R11: assert property (@(posedge clk) disable iff (rst)
        ((alu_valid & ~alu_lane_en) == '0) && ((tex_valid & ~tex_lane_en) == '0));

    // Grants never exceed the number of offered lanes
    assert_grant_count_R4: assert property (@(posedge clk) disable iff (rst)
        ($countones(alu_gr) <= $countones(alu_lane_en)) && ($countones(tex_gr) <= $countones(tex_lane_en)));

    generate
        for (genvar g = 0; g < NQ; g++) begin : g_retire_chk
            // Done lasts one cycle and then frees the entry
            assert_done_frees_R9: assert property (@(posedge clk) disable iff (rst)
                st_q[g] == Q_DONE |=> st_q[g] == Q_FREE);
        end
    endgenerate

endmodule

// File: tb/tb_quad_dispatch.sv
`timescale 1ns/1ps
module tb_quad_dispatch;
    localparam int NQ    = 16;
    localparam int L     = 4;
    localparam int PCW   = 5;
    localparam int QW    = 4;
    localparam int DEPTH = 32;
    localparam int TOTAL = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_valid = 1'b0, alloc_cond = 1'b0;
    logic [PCW-1:0] alloc_pc = '0;
    logic alloc_ready;
    logic [QW-1:0] alloc_id;
    logic [3*DEPTH-1:0] prog_image;
    logic [L-1:0] alu_lane_en = '1, tex_lane_en = '1;
    logic [L-1:0] alu_valid, tex_valid;
    logic [L*QW-1:0] alu_id, tex_id;
    logic [L*PCW-1:0] alu_pc, tex_pc;
    logic tex_ret_valid = 1'b0;
    logic [QW-1:0] tex_ret_id = '0;
    logic [NQ-1:0] retire_mask;

    int n_tests = 0, n_fail = 0;

    always #10 clk = ~clk;

    quad_dispatch #(.NQ(NQ), .LANES(L), .PCW(PCW)) dut (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_pc(alloc_pc),
        .alloc_cond(alloc_cond), .alloc_ready(alloc_ready), .alloc_id(alloc_id),
        .prog_image(prog_image), .alu_lane_en(alu_lane_en), .tex_lane_en(tex_lane_en),
        .alu_valid(alu_valid), .alu_id(alu_id), .alu_pc(alu_pc),
        .tex_valid(tex_valid), .tex_id(tex_id), .tex_pc(tex_pc),
        .tex_ret_valid(tex_ret_valid), .tex_ret_id(tex_ret_id), .retire_mask(retire_mask)
    );

    // Program words: {psel, class}; class 0 ALU, 1 TEX, 2 predicate-set, 3 end (R3)
    bit [2:0] rom [DEPTH];

    // Reference state: 0 free, 1 ready, 2 parked, 3 done
    int m_st [NQ];
    int m_pc [NQ];
    bit m_pred [NQ];
    bit m_cond [NQ];
    int m_aptr, m_tptr;
    int tq_id [$];
    int tq_t  [$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic mpick(input bit el [NQ], input int ptr, input bit [L-1:0] en,
                         output bit lv [L], output int lid [L], output bit gr [NQ], output int nptr);
        int sel [$];
        int navail;
        int r;
        navail = 0;
        for (int l = 0; l < L; l++) if (en[l]) navail++;
        for (int i = 0; i < NQ; i++) gr[i] = 0;
        for (int i = 0; i < NQ; i++) begin
            int idx;
            idx = (ptr + i) % NQ;
            if (el[idx] && sel.size() < navail) begin
                sel.push_back(idx);
                gr[idx] = 1;
            end
        end
        nptr = (sel.size() > 0) ? (sel[sel.size()-1] + 1) % NQ : ptr;
        r = 0;
        for (int l = 0; l < L; l++) begin
            lv[l] = 0; lid[l] = 0;
            if (en[l]) begin
                if (r < sel.size()) begin lv[l] = 1; lid[l] = sel[r]; end
                r++;
            end
        end
    endtask

    initial begin
        int cyc, launched, retired, free_i;
        bit [15:0] lfsr;
        bit ael [NQ];
        bit tel [NQ];
        bit agr [NQ];
        bit tgr [NQ];
        bit alv [L];
        bit tlv [L];
        int ali [L];
        int tli [L];
        int anp, tnp;
        bit busy, take, rv;
        int rid;

        for (int k = 0; k < DEPTH; k++) rom[k] = 3'b011;
        rom[0] = 3'b000; rom[1] = 3'b001; rom[2] = 3'b010; rom[3] = 3'b100;
        rom[4] = 3'b101; rom[5] = 3'b110; rom[6] = 3'b100; rom[7] = 3'b000;
        rom[8] = 3'b011;
        rom[10] = 3'b001; rom[11] = 3'b001; rom[12] = 3'b000; rom[13] = 3'b000;
        rom[14] = 3'b011;
        for (int k = 0; k < DEPTH; k++) prog_image[k*3 +: 3] = rom[k];
        for (int i = 0; i < NQ; i++) begin m_st[i] = 0; m_pc[i] = 0; m_pred[i] = 0; m_cond[i] = 0; end
        m_aptr = 0; m_tptr = 0;
        launched = 0; retired = 0; lfsr = 16'hACE1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1: reset state at the ports
        chk(alloc_ready == 1'b1, "R1", "alloc_ready after reset", alloc_ready, 1);
        chk(alloc_id == 0, "R1", "alloc_id after reset", alloc_id, 0);
        chk(alu_valid == 0 && tex_valid == 0, "R1", "lanes idle after reset", {alu_valid, tex_valid}, 0);
        chk(retire_mask == 0, "R1", "retire_mask after reset", retire_mask, 0);

        cyc = 0;
        busy = 1;
        while ((launched < TOTAL || busy) && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            alu_lane_en = (cyc < 40) ? 4'hF : lfsr[3:0];
            tex_lane_en = (cyc < 40) ? 4'hF : lfsr[7:4];
            alloc_valid = (launched < TOTAL) && (cyc % 4 != 3);
            alloc_pc    = (launched % 2 == 1) ? 5'd10 : 5'd0;
            alloc_cond  = launched[1];
            rv = 0; rid = 0;
            if (tq_id.size() > 0 && cyc - tq_t[0] >= 3) begin rv = 1; rid = tq_id[0]; end
            else if (tq_id.size() == 0 && cyc % 5 == 0) begin rv = 1; rid = cyc % NQ; end
            tex_ret_valid = rv;
            tex_ret_id    = QW'(rid);
            #1;

            free_i = -1;
            for (int i = NQ - 1; i >= 0; i--) if (m_st[i] == 0) free_i = i;
            for (int i = 0; i < NQ; i++) begin
                bit [2:0] w;
                bit run;
                w = rom[m_pc[i]];
                run = !(w[2] && !m_pred[i]);
                ael[i] = (m_st[i] == 1) && (w[1:0] == 2'd0) && run;
                tel[i] = (m_st[i] == 1) && (w[1:0] == 2'd1) && run;
            end
            mpick(ael, m_aptr, alu_lane_en, alv, ali, agr, anp);
            mpick(tel, m_tptr, tex_lane_en, tlv, tli, tgr, tnp);

            chk(alloc_ready == (free_i >= 0), "R2", "alloc_ready", alloc_ready, free_i >= 0);
            if (free_i >= 0) chk(alloc_id == QW'(free_i), "R2", "alloc_id lowest free", alloc_id, free_i);
            for (int l = 0; l < L; l++) begin
                chk(alu_valid[l] == alv[l], "R4 R7 R11", "alu_valid lane", alu_valid[l], alv[l]);
                chk(tex_valid[l] == tlv[l], "R5 R7 R11", "tex_valid lane", tex_valid[l], tlv[l]);
                if (alv[l]) begin
                    chk(alu_id[l*QW +: QW] == QW'(ali[l]), "R4 R10", "alu_id lane", alu_id[l*QW +: QW], ali[l]);
                    chk(alu_pc[l*PCW +: PCW] == PCW'(m_pc[ali[l]]), "R3 R8", "alu_pc lane", alu_pc[l*PCW +: PCW], m_pc[ali[l]]);
                end
                if (tlv[l]) begin
                    chk(tex_id[l*QW +: QW] == QW'(tli[l]), "R5 R10", "tex_id lane", tex_id[l*QW +: QW], tli[l]);
                    chk(tex_pc[l*PCW +: PCW] == PCW'(m_pc[tli[l]]), "R3 R6", "tex_pc lane", tex_pc[l*PCW +: PCW], m_pc[tli[l]]);
                end
                // R5: nothing on a lane may be a parked quad
                if (tex_valid[l]) chk(m_st[tex_id[l*QW +: QW]] == 1, "R5", "tex lane quad ready", m_st[tex_id[l*QW +: QW]], 1);
                if (alu_valid[l]) chk(m_st[alu_id[l*QW +: QW]] == 1, "R5", "alu lane quad ready", m_st[alu_id[l*QW +: QW]], 1);
            end
            for (int i = 0; i < NQ; i++)
                chk(retire_mask[i] == (m_st[i] == 3), "R9", "retire_mask bit", retire_mask[i], m_st[i] == 3);
            for (int i = 0; i < NQ; i++) if (retire_mask[i]) retired++;

            take = alloc_valid && (free_i >= 0);
            if (take) launched++;
            for (int i = 0; i < NQ; i++) begin
                bit [2:0] w;
                bit run;
                w = rom[m_pc[i]];
                run = !(w[2] && !m_pred[i]);
                case (m_st[i])
                    0: if (take && i == free_i) begin
                        m_st[i] = 1; m_pc[i] = alloc_pc; m_pred[i] = 1; m_cond[i] = alloc_cond;
                    end
                    3: m_st[i] = 0;
                    2: if (rv && rid == i) begin
                        m_st[i] = 1; m_pc[i] = (m_pc[i] + 1) % DEPTH;
                        void'(tq_id.pop_front()); void'(tq_t.pop_front());
                    end
                    default: case (w[1:0])
                        2'd3: m_st[i] = 3;
                        2'd2: begin m_pred[i] = m_cond[i] ^ w[2]; m_pc[i] = (m_pc[i] + 1) % DEPTH; end
                        2'd0: if (!run || agr[i]) m_pc[i] = (m_pc[i] + 1) % DEPTH;
                        default: if (!run) m_pc[i] = (m_pc[i] + 1) % DEPTH;
                                 else if (tgr[i]) begin m_st[i] = 2; tq_id.push_back(i); tq_t.push_back(cyc); end
                    endcase
                endcase
            end
            m_aptr = anp; m_tptr = tnp;
            busy = 0;
            for (int i = 0; i < NQ; i++) if (m_st[i] != 0) busy = 1;
        end
        alloc_valid = 1'b0; tex_ret_valid = 1'b0;

        // Watchdog: a run that never drains is a failure
        chk(cyc < 6000, "R9", "run drained before watchdog", cyc, 6000);
        // R9: every launched quad reached its end instruction and retired
        chk(retired == TOTAL, "R9", "retired quad count", retired, TOTAL);
        @(negedge clk); #1;
        chk(alloc_ready == 1'b1 && alloc_id == 0, "R2", "pool free after drain", alloc_id, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule